// File: doc/BRIEF.md
# Programmable Address Range Router

This block takes single requests from a processor-side port and sends each to one of two downstream targets: a main memory port or an I/O bus port. Every request carries an address, a read/write flag, write data and a space-select bit. When the space-select bit marks the I/O port space, the request always goes to the I/O bus. In that case only the low 16 bits of the address are used as a port number, in a space separate from memory.

Memory-space requests are checked against a small table of programmable non-memory ranges. The table is normally loaded at initialisation through a configuration port. Ranges are compared at page granularity: the page number is the address with its low `PAGE_BITS` bits removed. A memory-space request whose page falls in an enabled range goes to the I/O bus. Any other memory-space request goes to main memory. Every access routed to the I/O bus is reported back to the processor as uncacheable. Only one request is in flight at a time. Read data from the selected target is returned unchanged.

Top module: `addr_range_router`

## Requirements
- R1: A request with `req_io_i`=1 is sent to the I/O bus whatever its address. It carries `io_space_o`=1 and `io_addr_o` = zero-extended `req_addr_i[15:0]`, and `mem_valid_o` stays 0 for it.
- R2: A memory-space request (`req_io_i`=0) whose page number `req_addr_i[31:12]` lies within an enabled range, base <= page <= limit (both inclusive), goes to the I/O bus. It carries `io_space_o`=0 and the full address.
- R3: A memory-space request that matches no enabled range goes to the memory port with the full address, and `io_valid_o` stays 0 for it.
- R4: After reset, entry 0 is enabled with base page 0xA0 and limit page 0xFF, which covers byte addresses 0xA0000 to 0xFFFFF. Entries 1 to 3 are disabled.
- R5: A configuration write (`cfg_we_i`=1, with `cfg_idx_i` selecting entry 0 to 3) updates that entry at the clock edge. A request accepted at that same edge still sees the old entry. A request accepted at any later edge sees the new one.
- R6: A disabled entry never matches. An entry whose limit is below its base never matches.
- R7: When several enabled ranges overlap, a page inside any one of them is non-memory, and no error results.
- R8: The response carries `rsp_uncached_o`=1 when the access went to the I/O bus and 0 when it went to memory.
- R9: `req_ready_o` is 1 only when no request is in flight. The selected target's valid, address, write flag and write data stay stable until that target's ready is seen.
- R10: `rsp_valid_o` is raised in the cycle the selected target raises its response valid, with that target's read data unchanged. A response valid from the other target is ignored.
- R11: The write flag and write data of a request reach the selected target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Range table write strobe |
| cfg_idx_i | input | 2 | Entry to write |
| cfg_base_i | input | 20 | Base page number |
| cfg_limit_i | input | 20 | Limit page number (inclusive) |
| cfg_en_i | input | 1 | Entry enable |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when valid and ready |
| req_io_i | input | 1 | 1 = I/O port space, 0 = memory space |
| req_addr_i | input | 32 | Request address |
| req_we_i | input | 1 | 1 = write |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid (one cycle) |
| rsp_rdata_o | output | 32 | Read data from the selected target |
| rsp_uncached_o | output | 1 | Access must not be cached |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | 32 | Memory address |
| mem_we_o | output | 1 | Memory write flag |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rdata_i | input | 32 | Memory read data |
| io_valid_o | output | 1 | I/O bus request valid |
| io_ready_i | input | 1 | I/O bus accepts request |
| io_addr_o | output | 32 | I/O address (port number or memory address) |
| io_space_o | output | 1 | 1 = port space, 0 = memory-mapped |
| io_we_o | output | 1 | I/O write flag |
| io_wdata_o | output | 32 | I/O write data |
| io_rsp_valid_i | input | 1 | I/O response valid |
| io_rdata_i | input | 32 | I/O read data |

## Verification
A range table update and the acceptance of a request can fall on the same clock edge. To provoke this, the bench drives a configuration write that newly marks a page as non-memory in the same cycle as a valid request to that page. The first request must still reach memory. An identical request one cycle later must reach the I/O bus, and the bench also confirms that clearing the entry's enable returns the page to memory.

// File: rtl/arr_pkg.sv
package arr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } arr_state_e;
endpackage

// File: rtl/arr_range_table.sv
module arr_range_table #(
  parameter int NR           = 4,
  parameter int PGW          = 20,
  parameter logic [PGW-1:0] PRESET_BASE  = 20'h000A0,
  parameter logic [PGW-1:0] PRESET_LIMIT = 20'h000FF,
  localparam int IW          = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [IW-1:0]  cfg_idx_i,
  input  logic [PGW-1:0] cfg_base_i,
  input  logic [PGW-1:0] cfg_limit_i,
  input  logic           cfg_en_i,
  input  logic [PGW-1:0] page_i,
  output logic           nonmem_o
);
  logic [PGW-1:0] base_q  [NR];
  logic [PGW-1:0] limit_q [NR];
  logic [NR-1:0]  en_q;
  logic [NR-1:0]  hit;

  for (genvar g = 0; g < NR; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= (g == 0) ? PRESET_BASE  : '0;
        limit_q[g] <= (g == 0) ? PRESET_LIMIT : '0;
        en_q[g]    <= (g == 0);
      end else if (cfg_we_i && (cfg_idx_i == IW'(g))) begin
        base_q[g]  <= cfg_base_i;
        limit_q[g] <= cfg_limit_i;
        en_q[g]    <= cfg_en_i;
      end
    end
    // inverted range (limit < base) cannot satisfy both compares
    assign hit[g] = en_q[g] && (page_i >= base_q[g]) && (page_i <= limit_q[g]);
  end

  assign nonmem_o = |hit;

  AST_MATCH_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonmem_o |-> (en_q != '0)) else $error("match with no enabled entry"); // R6
endmodule

// File: rtl/arr_ctrl.sv
module arr_ctrl
  import arr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PORT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_io_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          nonmem_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_uncached_o,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          io_valid_o,
  input  logic          io_ready_i,
  input  logic          io_rsp_valid_i,
  input  logic [DW-1:0] io_rdata_i,
  output logic [AW-1:0] out_addr_o,
  output logic          out_we_o,
  output logic [DW-1:0] out_wdata_o,
  output logic          out_space_o
);
  arr_state_e     state_q, state_d;
  logic           to_io_q, space_q, we_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           accept, tgt_ready, tgt_rsp;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign tgt_ready = to_io_q ? io_ready_i : mem_ready_i;
  assign tgt_rsp   = to_io_q ? io_rsp_valid_i : mem_rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_ISSUE;
      ST_ISSUE: if (tgt_ready)   state_d = ST_WAIT;
      ST_WAIT:  if (tgt_rsp)     state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      to_io_q <= 1'b0;
      space_q <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        to_io_q <= req_io_i || nonmem_i;
        space_q <= req_io_i;
        we_q    <= req_we_i;
        addr_q  <= req_io_i ? AW'(req_addr_i[PORT_W-1:0]) : req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign mem_valid_o    = (state_q == ST_ISSUE) && !to_io_q;
  assign io_valid_o     = (state_q == ST_ISSUE) &&  to_io_q;
  assign out_addr_o     = addr_q;
  assign out_we_o       = we_q;
  assign out_wdata_o    = wdata_q;
  assign out_space_o    = space_q;
  assign rsp_valid_o    = (state_q == ST_WAIT) && tgt_rsp;
  assign rsp_rdata_o    = to_io_q ? io_rdata_i : mem_rdata_i;
  assign rsp_uncached_o = to_io_q;

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && io_valid_o)) else $error("both targets driven"); // R9
  AST_IO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_valid_o && !io_ready_i) |=> (io_valid_o && $stable(out_addr_o) && $stable(out_wdata_o)))
    else $error("io request dropped"); // R9
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(out_addr_o) && $stable(out_wdata_o)))
    else $error("mem request dropped"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !(mem_valid_o || io_valid_o || rsp_valid_o)) else $error("busy while idle"); // R9
  AST_RSP_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o) else $error("no release after response"); // R10
  AST_PORT_SPACE_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_io_i) |=> (io_valid_o && out_space_o)) else $error("port access misrouted"); // R1
endmodule

// File: rtl/addr_range_router.sv
module addr_range_router #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int NR        = 4,
  parameter int PORT_W    = 16,
  localparam int PGW      = AW - PAGE_BITS,
  localparam int IW       = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [IW-1:0]  cfg_idx_i,
  input  logic [PGW-1:0] cfg_base_i,
  input  logic [PGW-1:0] cfg_limit_i,
  input  logic           cfg_en_i,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_io_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic           req_we_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           rsp_valid_o,
  output logic [DW-1:0]  rsp_rdata_o,
  output logic           rsp_uncached_o,
  output logic           mem_valid_o,
  input  logic           mem_ready_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_we_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_rsp_valid_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           io_valid_o,
  input  logic           io_ready_i,
  output logic [AW-1:0]  io_addr_o,
  output logic           io_space_o,
  output logic           io_we_o,
  output logic [DW-1:0]  io_wdata_o,
  input  logic           io_rsp_valid_i,
  input  logic [DW-1:0]  io_rdata_i
);
  localparam logic [PGW-1:0] LEGACY_BASE  = PGW'((640 * 1024) >> PAGE_BITS);
  localparam logic [PGW-1:0] LEGACY_LIMIT = PGW'(((1024 * 1024) >> PAGE_BITS) - 1);

  logic           nonmem;
  logic [AW-1:0]  out_addr;
  logic           out_we, out_space;
  logic [DW-1:0]  out_wdata;

  arr_range_table #(
    .NR(NR), .PGW(PGW), .PRESET_BASE(LEGACY_BASE), .PRESET_LIMIT(LEGACY_LIMIT)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_base_i  (cfg_base_i),
    .cfg_limit_i (cfg_limit_i),
    .cfg_en_i    (cfg_en_i),
    .page_i      (req_addr_i[AW-1:PAGE_BITS]),
    .nonmem_o    (nonmem)
  );

  arr_ctrl #(.AW(AW), .DW(DW), .PORT_W(PORT_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_io_i        (req_io_i),
    .req_addr_i      (req_addr_i),
    .req_we_i        (req_we_i),
    .req_wdata_i     (req_wdata_i),
    .nonmem_i        (nonmem),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_rdata_o     (rsp_rdata_o),
    .rsp_uncached_o  (rsp_uncached_o),
    .mem_valid_o     (mem_valid_o),
    .mem_ready_i     (mem_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rdata_i     (mem_rdata_i),
    .io_valid_o      (io_valid_o),
    .io_ready_i      (io_ready_i),
    .io_rsp_valid_i  (io_rsp_valid_i),
    .io_rdata_i      (io_rdata_i),
    .out_addr_o      (out_addr),
    .out_we_o        (out_we),
    .out_wdata_o     (out_wdata),
    .out_space_o     (out_space)
  );

  assign mem_addr_o  = out_addr;
  assign mem_we_o    = out_we;
  assign mem_wdata_o = out_wdata;
  assign io_addr_o   = out_addr;
  assign io_we_o     = out_we;
  assign io_wdata_o  = out_wdata;
  assign io_space_o  = out_space;

  AST_UNCACHED_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_uncached_o) |-> !$past(io_valid_o)) else $error("cached io access"); // R8
endmodule

// File: tb/addr_range_router_test.sv
`timescale 1ns/1ps
module addr_range_router_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_idx_i = '0;
  logic [19:0] cfg_base_i = '0, cfg_limit_i = '0;
  logic        cfg_en_i = 1'b0;
  logic        req_valid_i = 1'b0, req_io_i = 1'b0, req_we_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_uncached_o;
  logic [31:0] rsp_rdata_o;
  logic        mem_valid_o, mem_ready_i = 1'b0, mem_we_o, mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic        io_valid_o, io_ready_i = 1'b0, io_space_o, io_we_o, io_rsp_valid_i = 1'b0;
  logic [31:0] io_addr_o, io_wdata_o, io_rdata_i = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  addr_range_router uut (.*);

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<20000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] idx, input logic [19:0] b, input logic [19:0] l, input logic en);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_base_i = b; cfg_limit_i = l; cfg_en_i = en;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // one full transaction; checks routing, hold, response, release
  task automatic xact(input string tag, input logic io, input logic [31:0] addr, input logic we,
                      input logic [31:0] wd, input logic exp_io);
    logic [31:0] exp_addr;
    logic [31:0] rd;
    exp_addr = io ? {16'h0, addr[15:0]} : addr;
    rd = addr ^ 32'h5A5A_C3C3;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_io_i = io; req_addr_i = addr; req_we_i = we; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_addr_i = 32'hDEAD_BEEF; req_wdata_i = 32'h0BAD_F00D;
    chk({tag, " io_valid"},  {31'h0, io_valid_o},  {31'h0, exp_io});
    chk({tag, " mem_valid"}, {31'h0, mem_valid_o}, {31'h0, !exp_io});
    chk({tag, " R9 busy"},   {31'h0, req_ready_o}, 32'h0);
    if (exp_io) begin
      chk({tag, " addr"},  io_addr_o, exp_addr);
      chk({tag, " space"}, {31'h0, io_space_o}, {31'h0, io});
      chk({tag, " R11 we"}, {31'h0, io_we_o}, {31'h0, we});
      chk({tag, " R11 wdata"}, io_wdata_o, wd);
    end else begin
      chk({tag, " addr"},  mem_addr_o, exp_addr);
      chk({tag, " R11 we"}, {31'h0, mem_we_o}, {31'h0, we});
      chk({tag, " R11 wdata"}, mem_wdata_o, wd);
    end
    // stall one cycle: request must hold
    @(negedge clk_i);
    chk({tag, " R9 hold"}, {31'h0, exp_io ? io_valid_o : mem_valid_o}, 32'h1);
    chk({tag, " R9 hold addr"}, exp_io ? io_addr_o : mem_addr_o, exp_addr);
    if (exp_io) io_ready_i = 1'b1; else mem_ready_i = 1'b1;
    @(negedge clk_i);
    io_ready_i = 1'b0; mem_ready_i = 1'b0;
    chk({tag, " R9 issued"}, {31'h0, io_valid_o | mem_valid_o}, 32'h0);
    // wrong target responds: must be ignored
    if (exp_io) begin mem_rsp_valid_i = 1'b1; mem_rdata_i = 32'hFFFF_0000; end
    else begin io_rsp_valid_i = 1'b1; io_rdata_i = 32'hFFFF_0000; end
    #1;
    chk({tag, " R10 other ignored"}, {31'h0, rsp_valid_o}, 32'h0);
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; io_rsp_valid_i = 1'b0;
    if (exp_io) begin io_rsp_valid_i = 1'b1; io_rdata_i = rd; end
    else begin mem_rsp_valid_i = 1'b1; mem_rdata_i = rd; end
    #1;
    chk({tag, " R10 rsp_valid"}, {31'h0, rsp_valid_o}, 32'h1);
    chk({tag, " R10 rdata"}, rsp_rdata_o, rd);
    chk({tag, " R8 uncached"}, {31'h0, rsp_uncached_o}, {31'h0, exp_io});
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; io_rsp_valid_i = 1'b0;
    chk({tag, " R9 ready again"}, {31'h0, req_ready_o}, 32'h1);
  endtask

  task automatic t_reset();
    chk("R9 reset ready", {31'h0, req_ready_o}, 32'h1);
    chk("R9 reset quiet", {29'h0, mem_valid_o, io_valid_o, rsp_valid_o}, 32'h0);
  endtask

  task automatic t_preset();
    xact("R4 low edge",   1'b0, 32'h000A_0000, 1'b0, '0, 1'b1);
    xact("R4 high edge",  1'b0, 32'h000F_FFFF, 1'b0, '0, 1'b1);
    xact("R4 below R3",   1'b0, 32'h0009_FFFF, 1'b0, '0, 1'b0);
    xact("R4 above R3",   1'b0, 32'h0010_0000, 1'b0, '0, 1'b0);
  endtask

  task automatic t_port_space();
    xact("R1 port hi bits", 1'b1, 32'h1234_0004, 1'b1, 32'hCAFE_0001, 1'b1);
    xact("R1 port in preset", 1'b1, 32'h000A_0010, 1'b0, '0, 1'b1);
    xact("R1 port low addr", 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0077, 1'b1);
  endtask

  task automatic t_range_write();
    xact("R2 write to range", 1'b0, 32'h000B_1234, 1'b1, 32'hA5A5_5A5A, 1'b1);
  endtask

  // config write and acceptance on the same edge
  task automatic t_same_edge();
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 2'd1; cfg_base_i = 20'h00200; cfg_limit_i = 20'h002FF; cfg_en_i = 1'b1;
    req_valid_i = 1'b1; req_io_i = 1'b0; req_addr_i = 32'h0020_0040; req_we_i = 1'b0;
    @(negedge clk_i);
    cfg_we_i = 1'b0; req_valid_i = 1'b0;
    chk("R5 same edge old table", {30'h0, io_valid_o, mem_valid_o}, 32'h1);
    mem_ready_i = 1'b1;
    @(negedge clk_i);
    mem_ready_i = 1'b0; mem_rsp_valid_i = 1'b1; mem_rdata_i = 32'h1111_2222;
    #1;
    chk("R5 same edge rsp", rsp_rdata_o, 32'h1111_2222);
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    xact("R5 next request new table", 1'b0, 32'h0020_0040, 1'b0, '0, 1'b1);
    xact("R5 range top", 1'b0, 32'h002F_FFFC, 1'b0, '0, 1'b1);
  endtask

  task automatic t_disabled();
    cfg(2'd1, 20'h00200, 20'h002FF, 1'b0);
    xact("R6 disabled", 1'b0, 32'h0020_0040, 1'b0, '0, 1'b0);
    cfg(2'd2, 20'h00300, 20'h002FF, 1'b1);
    xact("R6 inverted", 1'b0, 32'h0030_0000, 1'b0, '0, 1'b0);
    xact("R6 inverted below", 1'b0, 32'h002F_F000, 1'b0, '0, 1'b0);
  endtask

  task automatic t_overlap();
    cfg(2'd3, 20'h000B0, 20'h001FF, 1'b1);
    xact("R7 overlap both", 1'b0, 32'h000C_0000, 1'b0, '0, 1'b1);
    xact("R7 second only", 1'b0, 32'h0015_0000, 1'b0, '0, 1'b1);
    xact("R7 past both R3", 1'b0, 32'h0020_0000, 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_preset();
    t_port_space();
    t_range_write();
    t_same_edge();
    t_disabled();
    t_overlap();
    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule